// File: doc/BRIEF.md
# Debug Comparator Qualifier

This block decides whether any of a bank of hardware breakpoint or watchpoint comparators should actually fire. The address comparison happens elsewhere: it arrives here as one raw hit bit per comparator. Each comparator also has a control word, which the block decodes into an enable, a security-state filter, a privilege filter, a link flag and a link index. These fields are checked against the current exception level and security state. Breakpoint and watchpoint results are each reduced to a single fire bit.

A comparator can be linked to a context-aware breakpoint. That target must sit inside the window of breakpoint slots that can hold a context comparison. It must also be enabled, be of the context-ID type, and hold a value equal to the current context ID. Context matches are honoured only at levels 0 and 1. A watchpoint hit caused by an unprivileged load or store is qualified as if it came from level 0.

Both fire outputs are gated by a global enable bit in a debug control word and by a debug-exceptions-allowed input. Both are registered. A fault-status code that depends on the translation descriptor format is registered alongside them. The exception itself is raised downstream.

Top module: `dbg_match_qualifier`

## Requirements
- R1: `bp_fire`, `wp_fire` and `fault_status` are registered. An input change shows on them only after the next rising clock edge, and a synchronous `rst` forces all three to zero.
- R2: A comparator contributes only when its raw hit bit is 1 and its enable bit (control bit 0) is 1.
- R3: The security filter is control bits 15:14. Value 0 passes in both states, values 1 and 3 pass only when `secure` is 0, and value 2 passes only when `secure` is 1.
- R4: The privilege filter works on the qualifying level. At levels 2 and 3, control bit 13 must be 1. At level 1, control bit 1 must be 1. At level 0, control bit 2 must be 1.
- R5: For watchpoints the qualifying level is 0 whenever `wp_unpriv` is 1. Otherwise it is `cur_el`. Breakpoints always use `cur_el`.
- R6: When control bit 20 is 1, the comparator also needs its linked breakpoint, whose index is in control bits 19:16. The link fails if that index is outside NUM_BP-NUM_CTX to NUM_BP-1 (12 to 15 by default), or if the target's bit 0 is 0.
- R7: A linked target matches only if its bits 23:20 equal 3, `cur_el` is 0 or 1, and its 32-bit value word equals `context_id`. Any other type value never matches.
- R8: Both fire outputs are held at 0 when `dbg_ctrl` bit 15 is 0 or `exc_allowed` is 0.
- R9: `fault_status` is 0x222 when a fire output is set and `long_desc` was 1, 0x002 when a fire output is set and `long_desc` was 0, and 0 when neither fires.
- R10: Each fire output is the OR over all comparators of its kind that qualify.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bp_hit | input | NUM_BP | Raw address hit per breakpoint |
| wp_hit | input | NUM_WP | Raw address hit per watchpoint |
| bp_ctrl | input | NUM_BP*32 | Breakpoint control words, slot i at bits 32i+31:32i |
| wp_ctrl | input | NUM_WP*32 | Watchpoint control words |
| bp_value | input | NUM_BP*32 | Breakpoint value words, used when a slot is a link target |
| cur_el | input | 2 | Current exception level |
| secure | input | 1 | 1 when in the secure state |
| wp_unpriv | input | 1 | Watchpoint hit came from an unprivileged access |
| dbg_ctrl | input | 32 | Debug control word; bit 15 is the global enable |
| exc_allowed | input | 1 | Debug exceptions may be taken |
| context_id | input | 32 | Current context identifier |
| long_desc | input | 1 | Long descriptor format is in use |
| bp_fire | output | 1 | Registered breakpoint fire |
| wp_fire | output | 1 | Registered watchpoint fire |
| fault_status | output | 10 | Registered fault-status code |

## Verification
The assertions assume that every input is synchronous to `clk`, is known at each rising edge, and that reset is asserted before the first edge. They also assume that `long_desc` at the edge that loads a fire bit is the value the fault code must follow. The bench drives every input on the falling edge, holds it through the next rising edge, starts with reset high, and never leaves a field undefined. Its sweeps enumerate every security, privilege and level combination, every link index with several target types, and both gate inputs, all within those limits.

// File: rtl/dbgm_pkg.sv
package dbgm_pkg;
  localparam int CW       = 32;
  localparam int LIDX_W   = 4;
  localparam int KIND_W   = 4;
  localparam int LINK_SPAN = 1 << LIDX_W;
  localparam int FS_W     = 10;
  localparam int GATE_BIT = 15;

  localparam logic [FS_W-1:0]   FS_LONG  = 10'h222;
  localparam logic [FS_W-1:0]   FS_SHORT = 10'h002;
  localparam logic [KIND_W-1:0] KIND_CTX = 4'd3;

  typedef struct packed {
    logic [KIND_W-1:0] kind;
    logic [LIDX_W-1:0] link_idx;
    logic [1:0]        sec;
    logic              hi_mode;
    logic [1:0]        priv;
    logic              en;
  } ctl_t;
endpackage

// File: rtl/dbgm_ctl_split.sv
module dbgm_ctl_split
  import dbgm_pkg::*;
(
  input  logic [CW-1:0] word,
  output ctl_t          fld
);
  always_comb begin
    fld.en       = word[0];
    fld.priv     = word[2:1];
    fld.hi_mode  = word[13];
    fld.sec      = word[15:14];
    fld.link_idx = word[19:16];
    fld.kind     = word[23:20];
  end

  logic unused_ctl_bits;
  assign unused_ctl_bits = ^{word[CW-1:24], word[12:3]};
endmodule

// File: rtl/dbgm_mode_filter.sv
module dbgm_mode_filter (
  input  logic [1:0] sec,
  input  logic       hi_mode,
  input  logic [1:0] priv,
  input  logic [1:0] acc_el,
  input  logic       secure,
  output logic       pass
);
  logic sec_ok;
  logic lvl_ok;

  always_comb begin
    unique case (sec)
      2'd0:    sec_ok = 1'b1;
      2'd2:    sec_ok = secure;
      default: sec_ok = ~secure;
    endcase
  end

  always_comb begin
    unique case (acc_el)
      2'd0:    lvl_ok = priv[1];
      2'd1:    lvl_ok = priv[0];
      default: lvl_ok = hi_mode;
    endcase
  end

  assign pass = sec_ok & lvl_ok;
endmodule

// File: rtl/dbgm_link_table.sv
module dbgm_link_table
  import dbgm_pkg::*;
#(
  parameter int NUM_BP  = 16,
  parameter int NUM_CTX = 4
) (
  input  logic [NUM_BP-1:0]        tgt_en,
  input  logic [NUM_BP*KIND_W-1:0] tgt_kind,
  input  logic [NUM_BP*CW-1:0]     tgt_val,
  input  logic [1:0]               cur_el,
  input  logic [CW-1:0]            context_id,
  output logic [LINK_SPAN-1:0]     link_ok
);
  localparam int LO = NUM_BP - NUM_CTX;

  logic low_level;
  assign low_level = (cur_el <= 2'd1);

  for (genvar g = 0; g < LINK_SPAN; g++) begin : g_slot
    if (g >= LO && g < NUM_BP) begin : g_ctx
      assign link_ok[g] = tgt_en[g]
                        & (tgt_kind[g*KIND_W +: KIND_W] == KIND_CTX)
                        & low_level
                        & (tgt_val[g*CW +: CW] == context_id);
    end else if (g < NUM_BP) begin : g_plain
      logic unused_slot;
      assign unused_slot = ^{tgt_en[g], tgt_kind[g*KIND_W +: KIND_W], tgt_val[g*CW +: CW]};
      assign link_ok[g] = 1'b0;
    end else begin : g_pad
      assign link_ok[g] = 1'b0;
    end
  end
endmodule

// File: rtl/dbgm_bank.sv
module dbgm_bank
  import dbgm_pkg::*;
#(
  parameter int N = 16
) (
  input  logic [N-1:0]         hit,
  input  ctl_t                 fld [N],
  input  logic [1:0]           acc_el,
  input  logic                 secure,
  input  logic [LINK_SPAN-1:0] link_ok,
  output logic                 any
);
  logic [N-1:0] qual;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    logic pass;
    logic link_pass;
    logic unused_kind_hi;

    dbgm_mode_filter u_filt (
      .sec     (fld[g].sec),
      .hi_mode (fld[g].hi_mode),
      .priv    (fld[g].priv),
      .acc_el  (acc_el),
      .secure  (secure),
      .pass    (pass)
    );

    assign link_pass      = ~fld[g].kind[0] | link_ok[fld[g].link_idx];
    assign qual[g]        = hit[g] & fld[g].en & pass & link_pass;
    assign unused_kind_hi = ^fld[g].kind[KIND_W-1:1];
  end

  assign any = |qual;
endmodule

// File: rtl/dbg_match_qualifier.sv
module dbg_match_qualifier
  import dbgm_pkg::*;
#(
  parameter int NUM_BP  = 16,
  parameter int NUM_WP  = 16,
  parameter int NUM_CTX = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_BP-1:0]    bp_hit,
  input  logic [NUM_WP-1:0]    wp_hit,
  input  logic [NUM_BP*32-1:0] bp_ctrl,
  input  logic [NUM_WP*32-1:0] wp_ctrl,
  input  logic [NUM_BP*32-1:0] bp_value,
  input  logic [1:0]           cur_el,
  input  logic                 secure,
  input  logic                 wp_unpriv,
  input  logic [31:0]          dbg_ctrl,
  input  logic                 exc_allowed,
  input  logic [31:0]          context_id,
  input  logic                 long_desc,
  output logic                 bp_fire,
  output logic                 wp_fire,
  output logic [9:0]           fault_status
);
  ctl_t bp_f [NUM_BP];
  ctl_t wp_f [NUM_WP];

  logic [NUM_BP-1:0]        tgt_en;
  logic [NUM_BP*KIND_W-1:0] tgt_kind;
  logic [LINK_SPAN-1:0]     link_ok;

  for (genvar g = 0; g < NUM_BP; g++) begin : g_bp_dec
    dbgm_ctl_split u_split (.word(bp_ctrl[g*CW +: CW]), .fld(bp_f[g]));
    assign tgt_en[g]                    = bp_f[g].en;
    assign tgt_kind[g*KIND_W +: KIND_W] = bp_f[g].kind;
  end

  for (genvar g = 0; g < NUM_WP; g++) begin : g_wp_dec
    dbgm_ctl_split u_split (.word(wp_ctrl[g*CW +: CW]), .fld(wp_f[g]));
  end

  dbgm_link_table #(.NUM_BP(NUM_BP), .NUM_CTX(NUM_CTX)) u_link (
    .tgt_en     (tgt_en),
    .tgt_kind   (tgt_kind),
    .tgt_val    (bp_value),
    .cur_el     (cur_el),
    .context_id (context_id),
    .link_ok    (link_ok)
  );

  logic [1:0] wp_el;
  logic       bp_any;
  logic       wp_any;
  assign wp_el = wp_unpriv ? 2'd0 : cur_el;

  dbgm_bank #(.N(NUM_BP)) u_bp_bank (
    .hit(bp_hit), .fld(bp_f), .acc_el(cur_el), .secure(secure),
    .link_ok(link_ok), .any(bp_any)
  );

  dbgm_bank #(.N(NUM_WP)) u_wp_bank (
    .hit(wp_hit), .fld(wp_f), .acc_el(wp_el), .secure(secure),
    .link_ok(link_ok), .any(wp_any)
  );

  logic gate_ok;
  logic bp_nxt;
  logic wp_nxt;
  assign gate_ok = dbg_ctrl[GATE_BIT] & exc_allowed;
  assign bp_nxt  = gate_ok & bp_any;
  assign wp_nxt  = gate_ok & wp_any;

  logic unused_dbg_bits;
  assign unused_dbg_bits = ^{dbg_ctrl[31:GATE_BIT+1], dbg_ctrl[GATE_BIT-1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      bp_fire      <= 1'b0;
      wp_fire      <= 1'b0;
      fault_status <= '0;
    end else begin
      bp_fire      <= bp_nxt;
      wp_fire      <= wp_nxt;
      fault_status <= (bp_nxt | wp_nxt) ? (long_desc ? FS_LONG : FS_SHORT) : '0;
    end
  end
endmodule

// File: rtl/dbgm_checks.sv
module dbgm_checks #(
  parameter int NUM_BP = 16,
  parameter int NUM_WP = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [NUM_BP-1:0] bp_hit,
  input logic [NUM_WP-1:0] wp_hit,
  input logic              gate_bit,
  input logic              exc_allowed,
  input logic              long_desc,
  input logic              bp_fire,
  input logic              wp_fire,
  input logic [9:0]        fault_status
);
  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!bp_fire && !wp_fire && fault_status == 10'h0));

  p_bp_needs_hit_r2: assert property (@(posedge clk) disable iff (rst)
    (bp_hit == '0) |=> !bp_fire);

  p_wp_needs_hit_r2: assert property (@(posedge clk) disable iff (rst)
    (wp_hit == '0) |=> !wp_fire);

  p_gate_off_r8: assert property (@(posedge clk) disable iff (rst)
    !(gate_bit && exc_allowed) |=> (!bp_fire && !wp_fire));

  p_fs_code_r9: assert property (@(posedge clk) disable iff (rst)
    (bp_fire || wp_fire) |-> fault_status == ($past(long_desc) ? 10'h222 : 10'h002));

  p_fs_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !(bp_fire || wp_fire) |-> fault_status == 10'h0);
endmodule

bind dbg_match_qualifier dbgm_checks #(.NUM_BP(NUM_BP), .NUM_WP(NUM_WP)) u_checks (
  .clk          (clk),
  .rst          (rst),
  .bp_hit       (bp_hit),
  .wp_hit       (wp_hit),
  .gate_bit     (dbg_ctrl[15]),
  .exc_allowed  (exc_allowed),
  .long_desc    (long_desc),
  .bp_fire      (bp_fire),
  .wp_fire      (wp_fire),
  .fault_status (fault_status)
);

// File: tb/tb_dbg_match_qualifier.sv
`timescale 1ns/1ps
module tb_dbg_match_qualifier;
  localparam int NB = 16;
  localparam int NW = 16;
  localparam int NC = 4;
  localparam int CW = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic [31:0]   bctl [NB];
  logic [31:0]   bval [NB];
  logic [31:0]   wctl [NW];
  logic [NB-1:0] bhit;
  logic [NW-1:0] whit;
  logic [1:0]    el;
  logic          sec, unpriv, exc_ok, longd;
  logic [31:0]   dbgc, ctx;

  logic [NB*CW-1:0] bctl_f, bval_f;
  logic [NW*CW-1:0] wctl_f;

  always_comb begin
    for (int i = 0; i < NB; i++) begin
      bctl_f[i*CW +: CW] = bctl[i];
      bval_f[i*CW +: CW] = bval[i];
    end
    for (int i = 0; i < NW; i++) wctl_f[i*CW +: CW] = wctl[i];
  end

  logic       bp_fire, wp_fire;
  logic [9:0] fs;

  dbg_match_qualifier #(.NUM_BP(NB), .NUM_WP(NW), .NUM_CTX(NC)) dut (
    .clk(clk), .rst(rst), .bp_hit(bhit), .wp_hit(whit),
    .bp_ctrl(bctl_f), .wp_ctrl(wctl_f), .bp_value(bval_f),
    .cur_el(el), .secure(sec), .wp_unpriv(unpriv), .dbg_ctrl(dbgc),
    .exc_allowed(exc_ok), .context_id(ctx), .long_desc(longd),
    .bp_fire(bp_fire), .wp_fire(wp_fire), .fault_status(fs)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  task automatic cmp(string tag, string what, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s got %0h exp %0h at %0t", tag, what, got, exp, $time);
    end
  endtask

  // Requirement-level model of one comparator (R2..R7)
  function automatic bit m_qual(logic [31:0] c, bit h, logic [1:0] ael);
    bit sp, pp, lk;
    logic [3:0] li;
    if (!h || !c[0]) return 1'b0;
    case (c[15:14])
      2'd0:    sp = 1'b1;
      2'd2:    sp = sec;
      default: sp = !sec;
    endcase
    case (ael)
      2'd0:    pp = c[2];
      2'd1:    pp = c[1];
      default: pp = c[13];
    endcase
    if (!c[20]) lk = 1'b1;
    else begin
      li = c[19:16];
      lk = (int'(li) >= NB - NC) && bctl[li][0] && (bctl[li][23:20] == 4'd3)
           && (el <= 2'd1) && (bval[li] == ctx);
    end
    return sp && pp && lk;
  endfunction

  task automatic step_check(string tag);
    bit eb, ew, gate;
    @(posedge clk);
    @(negedge clk);
    gate = dbgc[15] && exc_ok;
    eb = 1'b0;
    ew = 1'b0;
    for (int i = 0; i < NB; i++) eb |= m_qual(bctl[i], bhit[i], el);
    for (int i = 0; i < NW; i++) ew |= m_qual(wctl[i], whit[i], unpriv ? 2'd0 : el);
    eb &= gate;
    ew &= gate;
    cmp(tag, "bp_fire", int'(bp_fire), int'(eb));
    cmp(tag, "wp_fire", int'(wp_fire), int'(ew));
    cmp({tag, " R9"}, "fault_status", int'(fs), (eb || ew) ? (longd ? 'h222 : 'h2) : 0);
  endtask

  task automatic clear_all();
    for (int i = 0; i < NB; i++) begin bctl[i] = '0; bval[i] = '0; end
    for (int i = 0; i < NW; i++) wctl[i] = '0;
    bhit = '0;
    whit = '0;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog expired got 0 exp 1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    clear_all();
    el = 2'd1; sec = 1'b0; unpriv = 1'b0; exc_ok = 1'b1; longd = 1'b0;
    dbgc = 32'h0000_8000; ctx = 32'h1234_5678;
    repeat (3) @(negedge clk);
    // R1: reset values
    cmp("R1", "bp_fire", int'(bp_fire), 0);
    cmp("R1", "wp_fire", int'(wp_fire), 0);
    cmp("R1", "fault_status", int'(fs), 0);

    // R1: qualifying stimulus held in reset stays quiet
    bctl[0] = 32'h0000_2007; bhit[0] = 1'b1;
    @(posedge clk); @(negedge clk);
    cmp("R1", "bp_fire under reset", int'(bp_fire), 0);
    rst = 1'b0;
    #1 cmp("R1", "bp_fire before edge", int'(bp_fire), 0);
    step_check("R1 R2");
    cmp("R1", "bp_fire after edge", int'(bp_fire), 1);

    // R2: enable and hit both required
    clear_all();
    bctl[4] = 32'h0000_2006; bhit[4] = 1'b1; step_check("R2");
    bctl[4] = 32'h0000_2007; bhit[4] = 1'b0; step_check("R2");
    wctl[9] = 32'h0000_2006; whit[9] = 1'b1; step_check("R2");

    // R3 R4: security and privilege sweep
    begin
      int n = 0;
      for (int l = 0; l < 4; l++)
        for (int s = 0; s < 2; s++)
          for (int sc = 0; sc < 4; sc++)
            for (int pc = 0; pc < 4; pc++)
              for (int hm = 0; hm < 2; hm++) begin
                int k = n % NB;
                int wk = (n + 5) % NW;
                clear_all();
                el = 2'(l); sec = 1'(s); longd = 1'(n >> 1);
                bctl[k]  = 32'(sc << 14) | 32'(hm << 13) | 32'(pc << 1) | 32'h1;
                wctl[wk] = bctl[k];
                bhit[k] = 1'b1; whit[wk] = 1'b1;
                step_check("R3 R4");
                n++;
              end
    end

    // R5: unprivileged watchpoint access qualifies at level 0
    sec = 1'b0; longd = 1'b1;
    for (int u = 0; u < 2; u++)
      for (int l = 0; l < 4; l++)
        for (int pc = 0; pc < 4; pc++)
          for (int hm = 0; hm < 2; hm++) begin
            clear_all();
            unpriv = 1'(u); el = 2'(l);
            wctl[7] = 32'(hm << 13) | 32'(pc << 1) | 32'h1; whit[7] = 1'b1;
            bctl[2] = wctl[7]; bhit[2] = 1'b1;
            step_check("R5");
          end
    unpriv = 1'b0;

    // R6 R7: linked context comparison
    for (int li = 0; li < 16; li++)
      for (int en = 0; en < 2; en++)
        for (int ty = 0; ty < 4; ty++)
          for (int mt = 0; mt < 2; mt++)
            for (int l = 0; l < 4; l++) begin
              logic [3:0] tv;
              clear_all();
              tv = (ty == 0) ? 4'd3 : (ty == 1) ? 4'd1 : (ty == 2) ? 4'd5 : 4'd11;
              el = 2'(l); sec = 1'(li & 1); longd = 1'(li >> 2);
              bctl[li] = 32'(tv << 20) | 32'(en);
              bval[li] = mt ? ctx : (ctx ^ 32'h1);
              bctl[0]  = 32'h0010_2007 | 32'(li << 16);
              wctl[3]  = 32'h0010_2007 | 32'(li << 16);
              bhit[0] = 1'b1; whit[3] = 1'b1;
              step_check("R6 R7");
            end

    // R8: global enable and exception permission
    for (int d = 0; d < 4; d++)
      for (int e = 0; e < 2; e++) begin
        clear_all();
        el = 2'd0; sec = 1'b1;
        dbgc = (d == 0) ? 32'h0 : (d == 1) ? 32'h0000_8000 : (d == 2) ? 32'hFFFF_7FFF : 32'hFFFF_FFFF;
        exc_ok = 1'(e);
        bctl[6] = 32'h0000_0005; bhit[6] = 1'b1;
        wctl[1] = 32'h0000_8005; whit[1] = 1'b1;
        step_check("R8");
      end
    dbgc = 32'h0000_8000; exc_ok = 1'b1;

    // R2 R10: mixed random banks
    void'($urandom(32'd77));
    for (int it = 0; it < 300; it++) begin
      for (int i = 0; i < NB; i++) begin
        bctl[i] = $urandom & ((it % 3 == 0) ? 32'h00FF_E007 : 32'h00EF_E007);
        bval[i] = ($urandom % 2 == 0) ? ctx : $urandom;
      end
      for (int i = 0; i < NW; i++)
        wctl[i] = $urandom & ((it % 2 == 0) ? 32'h00FF_E007 : 32'h00EF_E007);
      bhit = 16'($urandom); whit = 16'($urandom);
      el = 2'($urandom); sec = 1'($urandom); unpriv = 1'($urandom);
      longd = 1'($urandom);
      step_check("R2 R10");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule